// File: doc/BRIEF.md
# Control-Flow and Data-Movement Sequencer

This block is a multicycle sequencer for a 64-bit machine. It runs the compare, conditional-jump, load, store, register-copy, memory-copy, immediate-load, halt and no-op instructions. It keeps a program counter and a two-bit flags register. Bit 0 of the flags is the halt flag and bit 1 is the compare flag. Arithmetic operations are handled elsewhere.

Instructions are 2, 4, 8 or 12 bytes long, and the opcode sets the length. One synchronous memory port carries both instruction fetches and data accesses. The port is byte addressed. Each read returns the 64-bit big-endian word at the given address, one cycle after the read strobe. A fetch therefore returns a 64-bit window, and the opcode sits in bits 63:48 of that window. The register file is kept outside the block. The sequencer reaches it through two combinational read ports and one write port.

Each instruction takes a fetch cycle, a decode cycle and an execute cycle. Load, memory copy and the 64-bit immediate load take one more cycle.

Top module: `cfSequencer`

## Requirements
- R1: While reset is asserted and right after it is released, the PC is 0, the flags are 0, and neither write strobe (memory or register) is active.
- R2: Each non-jump instruction advances the PC by its length. Halt and no-op are 2 bytes, register-form instructions are 4 bytes, the 32-bit immediate load is 8 bytes and the 64-bit immediate load is 12 bytes. In a fetch window, REG1 is in bits 47:42 and REG2 is in bits 41:36.
- R3: Opcode 0x1000 sets flag bit 1 to (REG1 == REG2). Opcode 0x1001 sets flag bit 1 to (REG1 < REG2), compared unsigned. Both clear the bit when the test is false.
- R4: Opcode 0x1100 loads the PC from REG1 when flag bit 1 is 0. Opcode 0x1101 loads the PC from REG1 when flag bit 1 is 1. If the jump is not taken, the PC advances by 4. No jump changes the compare flag.
- R5: Opcode 0x2000 writes the memory word at address REG2 into REG1. Opcode 0x2201 writes REG1 to the memory word at address REG2. A single cycle never carries both a register write and a memory write.
- R6: Opcode 0x2001 copies REG2 into REG1. Opcode 0x2200 reads the word at address REG2 and writes it to address REG1 in a later cycle.
- R7: Opcode 0x2101 writes window bits 31:0, zero-extended to 64 bits, into REG1.
- R8: Opcode 0x2100 writes into REG1 the 64-bit word stored 4 bytes after the start of the instruction.
- R9: Opcode 0xF000 sets flag bit 0. While flag bit 0 is set, there are no fetches, memory accesses or register writes until reset. Opcode 0xF001 has no effect other than advancing the PC.
- R10: Any other opcode behaves as a 2-byte no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| memAddr | output | 64 | Byte address for fetch or data access |
| memRdEn | output | 1 | Read strobe; data returns next cycle |
| memRdData | input | 64 | Big-endian word read at memAddr |
| memWrEn | output | 1 | Write strobe |
| memWrData | output | 64 | Word to write |
| rfRdAddr1 | output | 6 | REG1 index |
| rfRdData1 | input | 64 | Value of REG1 |
| rfRdAddr2 | output | 6 | REG2 index |
| rfRdData2 | input | 64 | Value of REG2 |
| rfWrEn | output | 1 | Register write strobe |
| rfWrAddr | output | 6 | Register write index (REG1) |
| rfWrData | output | 64 | Register write value |
| pcOut | output | 64 | Current program counter |
| flagsOut | output | 2 | Flags: bit 0 halt, bit 1 compare |

## Verification
The test program mixes every instruction length. A PC-advance error therefore desynchronises the fetch stream and produces an unexpected write.

Each conditional jump is run both taken and not taken. The not-taken path of each jump leads to a poisoned instruction that writes a register. This separates the Jz sense from the Jnz sense and shows that the compare flag is sticky.

An unsigned-less-than case with an all-ones operand distinguishes an unsigned compare from a signed one.

A store followed by a load and a memory copy of the same word checks the data path and the read-then-write order. A final halt, followed by poisoned code, shows that fetching stops.

// File: rtl/cfSeqPkg.sv
package cfSeqPkg;

  localparam logic [15:0] OP_CMPEQ   = 16'h1000;
  localparam logic [15:0] OP_CMPLT   = 16'h1001;
  localparam logic [15:0] OP_JZ      = 16'h1100;
  localparam logic [15:0] OP_JNZ     = 16'h1101;
  localparam logic [15:0] OP_LOAD    = 16'h2000;
  localparam logic [15:0] OP_REGCOPY = 16'h2001;
  localparam logic [15:0] OP_IMM64   = 16'h2100;
  localparam logic [15:0] OP_IMM32   = 16'h2101;
  localparam logic [15:0] OP_MEMCOPY = 16'h2200;
  localparam logic [15:0] OP_STORE   = 16'h2201;
  localparam logic [15:0] OP_HALT    = 16'hF000;
  localparam logic [15:0] OP_NOP     = 16'hF001;

  typedef enum logic [1:0] {PC_HOLD, PC_ADV, PC_JUMP} pcOp_e;
  typedef enum logic [1:0] {ADDR_PC, ADDR_PC4, ADDR_R1, ADDR_R2} addrSel_e;
  typedef enum logic [1:0] {WB_MEM, WB_R2, WB_IMM32} wbSel_e;

  typedef struct packed {
    logic     latchInstr;
    pcOp_e    pcOp;
    logic     cmpWr;
    logic     haltSet;
    logic     memRd;
    logic     memWr;
    logic     wrFromMem;
    addrSel_e addrSel;
    logic     rfWr;
    wbSel_e   wbSel;
  } seqStrobe_t;

  // Instruction length in bytes, selected by opcode
  function automatic logic [3:0] instrLen(input logic [15:0] op);
    case (op)
      OP_CMPEQ, OP_CMPLT, OP_JZ, OP_JNZ, OP_LOAD,
      OP_REGCOPY, OP_MEMCOPY, OP_STORE:  instrLen = 4'd4;
      OP_IMM32:                          instrLen = 4'd8;
      OP_IMM64:                          instrLen = 4'd12;
      default:                           instrLen = 4'd2;
    endcase
  endfunction

endpackage

// File: rtl/cfSeqCtrl.sv
module cfSeqCtrl
  import cfSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [15:0] opcode,
  input  logic       cmpFlag,
  input  logic       haltFlag,
  output seqStrobe_t strb
);

  typedef enum logic [2:0] {S_FETCH, S_DECODE, S_EXEC, S_SECOND, S_HALT} state_e;
  state_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_FETCH;
    else       state <= stateNext;
  end

  always_comb begin
    strb      = '0;
    strb.pcOp = PC_HOLD;
    stateNext = state;
    case (state)
      S_FETCH: begin
        strb.memRd   = 1'b1;
        strb.addrSel = ADDR_PC;
        stateNext    = S_DECODE;
      end
      S_DECODE: begin
        strb.latchInstr = 1'b1;
        stateNext       = S_EXEC;
      end
      S_EXEC: begin
        stateNext = S_FETCH;
        case (opcode)
          OP_CMPEQ, OP_CMPLT: begin
            strb.cmpWr = 1'b1;
            strb.pcOp  = PC_ADV;
          end
          OP_JZ:  strb.pcOp = cmpFlag ? PC_ADV : PC_JUMP;
          OP_JNZ: strb.pcOp = cmpFlag ? PC_JUMP : PC_ADV;
          OP_LOAD, OP_MEMCOPY: begin
            strb.memRd   = 1'b1;
            strb.addrSel = ADDR_R2;
            stateNext    = S_SECOND;
          end
          OP_IMM64: begin
            strb.memRd   = 1'b1;
            strb.addrSel = ADDR_PC4;
            stateNext    = S_SECOND;
          end
          OP_STORE: begin
            strb.memWr   = 1'b1;
            strb.addrSel = ADDR_R2;
            strb.pcOp    = PC_ADV;
          end
          OP_REGCOPY: begin
            strb.rfWr  = 1'b1;
            strb.wbSel = WB_R2;
            strb.pcOp  = PC_ADV;
          end
          OP_IMM32: begin
            strb.rfWr  = 1'b1;
            strb.wbSel = WB_IMM32;
            strb.pcOp  = PC_ADV;
          end
          OP_HALT: begin
            strb.haltSet = 1'b1;
            strb.pcOp    = PC_ADV;
            stateNext    = S_HALT;
          end
          default: strb.pcOp = PC_ADV;
        endcase
      end
      S_SECOND: begin
        stateNext = S_FETCH;
        strb.pcOp = PC_ADV;
        if (opcode == OP_MEMCOPY) begin
          strb.memWr     = 1'b1;
          strb.wrFromMem = 1'b1;
          strb.addrSel   = ADDR_R1;
        end else begin
          strb.rfWr  = 1'b1;
          strb.wbSel = WB_MEM;
        end
      end
      default: stateNext = S_HALT;
    endcase
  end

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    haltFlag |-> (!strb.memRd && !strb.memWr && !strb.rfWr)); // R9

  AST_COPY_READ_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (strb.memWr && strb.wrFromMem) |-> $past(strb.memRd)); // R6

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.rfWr && strb.memWr)); // R5

endmodule

// File: rtl/cfSeqDatapath.sv
module cfSeqDatapath
  import cfSeqPkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int REG_IDX_W = 6,
  parameter logic [63:0] RESET_PC = '0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobe_t           strb,
  output logic [15:0]          opcode,
  output logic                 cmpFlag,
  output logic                 haltFlag,
  output logic [DATA_W-1:0]    memAddr,
  input  logic [DATA_W-1:0]    memRdData,
  output logic [DATA_W-1:0]    memWrData,
  output logic [REG_IDX_W-1:0] rfRdAddr1,
  input  logic [DATA_W-1:0]    rfRdData1,
  output logic [REG_IDX_W-1:0] rfRdAddr2,
  input  logic [DATA_W-1:0]    rfRdData2,
  output logic [REG_IDX_W-1:0] rfWrAddr,
  output logic [DATA_W-1:0]    rfWrData,
  output logic [DATA_W-1:0]    pcOut,
  output logic [1:0]           flagsOut
);

  localparam int OPC_LO  = DATA_W - 16;
  localparam int R1_LO   = OPC_LO - REG_IDX_W;
  localparam int R2_LO   = R1_LO - REG_IDX_W;
  localparam int IMM_W   = 32;
  localparam logic [DATA_W-1:0] HDR_BYTES = DATA_W'(4);

  logic [DATA_W-1:0] pc, instrReg;
  logic [1:0]        flags;
  logic              cmpResult;
  logic [R2_LO-IMM_W-1:0] unusedGap;

  assign opcode    = instrReg[DATA_W-1:OPC_LO];
  assign rfRdAddr1 = instrReg[OPC_LO-1:R1_LO];
  assign rfRdAddr2 = instrReg[R1_LO-1:R2_LO];
  assign rfWrAddr  = rfRdAddr1;
  assign unusedGap = instrReg[R2_LO-1:IMM_W];
  assign cmpFlag   = flags[1];
  assign haltFlag  = flags[0];
  assign pcOut     = pc;
  assign flagsOut  = flags;

  assign cmpResult = (opcode == OP_CMPLT) ? (rfRdData1 < rfRdData2)
                                          : (rfRdData1 == rfRdData2);

  always_comb begin
    case (strb.addrSel)
      ADDR_PC:  memAddr = pc;
      ADDR_PC4: memAddr = pc + HDR_BYTES;
      ADDR_R1:  memAddr = rfRdData1;
      default:  memAddr = rfRdData2;
    endcase
  end

  assign memWrData = strb.wrFromMem ? memRdData : rfRdData1;

  always_comb begin
    case (strb.wbSel)
      WB_MEM:  rfWrData = memRdData;
      WB_R2:   rfWrData = rfRdData2;
      default: rfWrData = {{(DATA_W-IMM_W){1'b0}}, instrReg[IMM_W-1:0]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc       <= RESET_PC[DATA_W-1:0];
      flags    <= '0;
      instrReg <= '0;
    end else begin
      if (strb.latchInstr) instrReg <= memRdData;
      case (strb.pcOp)
        PC_ADV:  pc <= pc + DATA_W'(instrLen(opcode));
        PC_JUMP: pc <= rfRdData1;
        default: pc <= pc;
      endcase
      if (strb.cmpWr)   flags[1] <= cmpResult;
      if (strb.haltSet) flags[0] <= 1'b1;
    end
  end

  AST_CMP_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cmpWr |=> $stable(flags[1])); // R4

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    flags[0] |=> flags[0]); // R9

endmodule

// File: rtl/cfSequencer.sv
module cfSequencer
  import cfSeqPkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int REG_IDX_W = 6,
  parameter logic [63:0] RESET_PC = '0
) (
  input  logic                 clk,
  input  logic                 rstN,
  output logic [DATA_W-1:0]    memAddr,
  output logic                 memRdEn,
  input  logic [DATA_W-1:0]    memRdData,
  output logic                 memWrEn,
  output logic [DATA_W-1:0]    memWrData,
  output logic [REG_IDX_W-1:0] rfRdAddr1,
  input  logic [DATA_W-1:0]    rfRdData1,
  output logic [REG_IDX_W-1:0] rfRdAddr2,
  input  logic [DATA_W-1:0]    rfRdData2,
  output logic                 rfWrEn,
  output logic [REG_IDX_W-1:0] rfWrAddr,
  output logic [DATA_W-1:0]    rfWrData,
  output logic [DATA_W-1:0]    pcOut,
  output logic [1:0]           flagsOut
);

  seqStrobe_t  strb;
  logic [15:0] opcode;
  logic        cmpFlag, haltFlag;

  cfSeqCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .opcode(opcode),
    .cmpFlag(cmpFlag), .haltFlag(haltFlag), .strb(strb)
  );

  cfSeqDatapath #(.DATA_W(DATA_W), .REG_IDX_W(REG_IDX_W), .RESET_PC(RESET_PC)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .opcode(opcode),
    .cmpFlag(cmpFlag), .haltFlag(haltFlag),
    .memAddr(memAddr), .memRdData(memRdData), .memWrData(memWrData),
    .rfRdAddr1(rfRdAddr1), .rfRdData1(rfRdData1),
    .rfRdAddr2(rfRdAddr2), .rfRdData2(rfRdData2),
    .rfWrAddr(rfWrAddr), .rfWrData(rfWrData),
    .pcOut(pcOut), .flagsOut(flagsOut)
  );

  assign memRdEn = strb.memRd;
  assign memWrEn = strb.memWr;
  assign rfWrEn  = strb.rfWr;

endmodule

// File: tb/cfSequencer_tb_top.sv
module cfSequencer_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] memAddr, memRdData, memWrData;
  logic        memRdEn, memWrEn, rfWrEn;
  logic [5:0]  rfRdAddr1, rfRdAddr2, rfWrAddr;
  logic [63:0] rfRdData1, rfRdData2, rfWrData, pcOut;
  logic [1:0]  flagsOut;

  always #10 clk = ~clk;  // 50 MHz

  cfSequencer dut_i (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memRdEn(memRdEn),
    .memRdData(memRdData), .memWrEn(memWrEn), .memWrData(memWrData),
    .rfRdAddr1(rfRdAddr1), .rfRdData1(rfRdData1),
    .rfRdAddr2(rfRdAddr2), .rfRdData2(rfRdData2),
    .rfWrEn(rfWrEn), .rfWrAddr(rfWrAddr), .rfWrData(rfWrData),
    .pcOut(pcOut), .flagsOut(flagsOut)
  );

  // Memory and register file models
  logic [7:0]  mem [512];
  logic [63:0] rf  [64];

  assign rfRdData1 = rf[rfRdAddr1];
  assign rfRdData2 = rf[rfRdAddr2];

  always @(posedge clk) begin
    if (memRdEn)
      for (int b = 0; b < 8; b++) memRdData[63-8*b -: 8] <= mem[(memAddr[8:0] + 9'(b))];
    if (memWrEn)
      for (int b = 0; b < 8; b++) mem[(memAddr[8:0] + 9'(b))] <= memWrData[63-8*b -: 8];
    if (rfWrEn) rf[rfWrAddr] <= rfWrData;
  end

  // Scoreboard
  typedef struct {
    bit          isMem;
    logic [63:0] addr;
    logic [63:0] data;
    string       req;
  } item_t;
  item_t expQ[$];

  int checks = 0;
  int failures = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic expectWrite(input bit isMem, input logic [63:0] addr,
                             input logic [63:0] data, input string req);
    item_t it;
    it.isMem = isMem; it.addr = addr; it.data = data; it.req = req;
    expQ.push_back(it);
  endtask

  always @(negedge clk) begin
    if (rstN && (rfWrEn || memWrEn)) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2/R4", memWrEn ? "unexpected mem write" : "unexpected reg write",
              memWrEn ? memAddr : 64'(rfWrAddr), 64'h0);
      end else begin
        item_t it;
        logic [63:0] actAddr, actData;
        it = expQ.pop_front();
        actAddr = memWrEn ? memAddr : 64'(rfWrAddr);
        actData = memWrEn ? memWrData : rfWrData;
        check(it.isMem == memWrEn, it.req, "write kind", 64'(memWrEn), 64'(it.isMem));
        check(actAddr == it.addr, it.req, "write address", actAddr, it.addr);
        check(actData == it.data, it.req, "write data", actData, it.data);
      end
    end
  end

  // Program encoding helpers (big-endian)
  task automatic putBytes(input int addr, input logic [63:0] val, input int n);
    for (int i = 0; i < n; i++) mem[addr + i] = val[8*(n-1-i) +: 8];
  endtask

  function automatic logic [31:0] regForm(input logic [15:0] op, input int r1, input int r2);
    return {op, 6'(r1), 6'(r2), 4'h0};
  endfunction

  task automatic putReg(input int addr, input logic [15:0] op, input int r1, input int r2);
    putBytes(addr, 64'(regForm(op, r1, r2)), 4);
  endtask

  localparam logic [63:0] BIG = 64'h0123_4567_89AB_CDEF;

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'h00;
    for (int i = 0; i < 64; i++) rf[i] = 64'h0;
    rf[1] = 64'h100; rf[2] = 64'h108; rf[3] = 64'd5; rf[4] = 64'd7;
    rf[5] = 64'h1F0; rf[6] = 64'h40; rf[7] = 64'h1F0; rf[8] = 64'h60;
    rf[9] = '1;      rf[14] = 64'h70;

    putBytes(16'h00, {16'h2101, 6'd10, 6'd0, 4'h0, 32'hDEAD_BEEF}, 8);
    expectWrite(0, 64'd10, 64'h0000_0000_DEAD_BEEF, "R7");
    putReg(16'h08, 16'h2100, 11, 0); putBytes(16'h0C, BIG, 8);
    expectWrite(0, 64'd11, BIG, "R8");
    putReg(16'h14, 16'h2001, 12, 11);
    expectWrite(0, 64'd12, BIG, "R6");
    putReg(16'h18, 16'h2201, 11, 1);
    expectWrite(1, 64'h100, BIG, "R5");
    putReg(16'h1C, 16'h2000, 13, 1);
    expectWrite(0, 64'd13, BIG, "R5");
    putReg(16'h20, 16'h2200, 2, 1);
    expectWrite(1, 64'h108, BIG, "R6");
    putBytes(16'h24, 64'hF001, 2);          // no-op
    putReg(16'h26, 16'h1001, 3, 4);         // 5<7 -> flag 1
    putReg(16'h2A, 16'h1100, 5, 0);         // Jz not taken
    putReg(16'h2E, 16'h1101, 6, 0);         // Jnz taken to 0x40
    putReg(16'h32, 16'h2001, 21, 3);        // poison
    putReg(16'h40, 16'h1000, 3, 4);         // 5==7 -> flag 0
    putReg(16'h44, 16'h1101, 7, 0);         // Jnz not taken
    putReg(16'h48, 16'h1100, 8, 0);         // Jz taken to 0x60
    putReg(16'h4C, 16'h2001, 21, 3);        // poison
    putReg(16'h60, 16'h1000, 3, 3);         // equal -> flag 1
    putReg(16'h64, 16'h1001, 9, 3);         // unsigned all-ones < 5 false -> flag 0
    putReg(16'h68, 16'h1100, 14, 0);        // Jz taken to 0x70
    putReg(16'h6C, 16'h2001, 21, 3);        // poison
    putBytes(16'h70, 64'h0000, 2);          // unknown opcode, 2-byte no-op
    putBytes(16'h72, 64'hF000, 2);          // halt
    putBytes(16'h74, {16'h2101, 6'd22, 6'd0, 4'h0, 32'h1}, 8); // never run
    putReg(16'h1F0, 16'h2001, 21, 3);       // poison on wrong jump
    putBytes(16'h1F4, 64'hF000, 2);

    // R1: reset state
    repeat (3) @(negedge clk);
    check(pcOut == 64'h0, "R1", "pc in reset", pcOut, 64'h0);
    check(flagsOut == 2'b00, "R1", "flags in reset", 64'(flagsOut), 64'h0);
    check(!memWrEn && !rfWrEn, "R1", "write strobes in reset",
          64'({memWrEn, rfWrEn}), 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(pcOut == 64'h0 && flagsOut == 2'b00, "R1", "state after reset release",
          pcOut, 64'h0);

    begin : runLoop
      int cyc = 0;
      while (!flagsOut[0] && cyc < 5000) begin
        @(negedge clk);
        cyc++;
      end
      if (!flagsOut[0]) check(1'b0, "R9", "watchdog expired before halt", 64'(cyc), 64'd5000);
    end

    // R9: quiet after halt
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (memRdEn || memWrEn || rfWrEn)
        check(1'b0, "R9", "activity while halted", 64'({memRdEn, memWrEn, rfWrEn}), 64'h0);
    end
    checks++;
    check(pcOut == 64'h74, "R2", "final pc (R10 2-byte unknown, R9 halt length)",
          pcOut, 64'h74);
    check(flagsOut == 2'b01, "R9", "final flags (R3 unsigned compare clears bit 1)",
          64'(flagsOut), 64'h1);
    check(expQ.size() == 0, "R5", "writes still pending", 64'(expQ.size()), 64'h0);
    check(rf[21] == 64'h0 && rf[22] == 64'h0, "R4", "poisoned registers untouched",
          rf[21] | rf[22], 64'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule